// File: doc/BRIEF.md
# Dual-Width Add/Subtract Unit with Condition Flags

This block is the integer add/subtract stage of an execution pipeline. For each operation it takes operand A, a raw operand B, a carry-in and a set of mode controls. It produces a registered result and, when asked, the four condition flags: negative, zero, carry and overflow.

Each operation runs either 32 bits wide or 64 bits wide. Before the add, operand B can go through one of two conditioning paths. The shift path applies a logical left, logical right, arithmetic right or rotate right shift. The extend path zero- or sign-extends a byte, halfword, word or doubleword and then shifts it left by a small amount. Masking, sign position, rotate wrap-around and the position of the carry and overflow bits all follow the width chosen for that operation. The same datapath serves both widths.

Decode, register read and write-back are handled elsewhere. A decoder drives the mode pins directly from its instruction fields.

Top module: `addsub_flags`

## Requirements
- R1: The result and `out_valid` are registered. `out_valid` is high in the cycle after `in_valid` was sampled high, and low otherwise. After reset, `out_valid`, `result` and all four flags are 0.
- R2: When `wide` is 0 (32-bit mode), both operands are cut to bits 31:0 before the add, and `result[63:32]` is always zero.
- R3: With `sub` = 0 the result is A + B' + `carry_in`, where B' is the conditioned operand B. With `sub` = 1 the result is A + ~B' + `carry_in`, so `carry_in` = 1 gives A − B'. Both are taken modulo 2^width.
- R4: `flag_c` is the carry out of the selected width: it is 1 when the unsigned sum of A, the added B term and `carry_in` exceeds 2^width − 1.
- R5: `flag_v` is 1 when A and the added B term have the same sign bit and the result's sign bit differs from it. The sign bit is bit 31 in 32-bit mode and bit 63 in 64-bit mode. `flag_n` equals that sign bit of the result. `flag_z` is 1 when all bits of the selected width are zero.
- R6: The flags load only when `in_valid` and `set_flags` are both high. Otherwise they hold their values, while `result` still updates on every `in_valid`.
- R7: `b_sel` picks the source of B': 0 or 3 is the raw `op_b`, 1 is the shift path and 2 is the extend path.
- R8: `sh_kind` encodes the shift: 0 is LSL, 1 is LSR, 2 is ASR and 3 is ROR. The value is first masked to the selected width. ASR fills from bit 31 or bit 63 according to the width. ROR wraps within 32 or 64 bits. The shift output is masked to the width.
- R9: A shift amount of zero passes the width-masked operand through unchanged for every shift kind. In 32-bit mode only `sh_amt[4:0]` is used.
- R10: `ext_kind[1:0]` selects the source size: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. `ext_kind[2]` = 1 sign-extends and 0 zero-extends. The extended value is shifted left by `ext_lsl` (0 to 4) and masked to the selected width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit |
| sub | input | 1 | 1 = add the inverse of B' |
| set_flags | input | 1 | Load the flags from this operation |
| carry_in | input | 1 | Carry into bit 0 |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Raw operand B |
| b_sel | input | 2 | B' source select |
| sh_kind | input | 2 | Shift kind |
| sh_amt | input | 6 | Shift amount |
| ext_kind | input | 3 | Extend sign and source size |
| ext_lsl | input | 3 | Left shift after extend |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The assertions check on every cycle the properties that relate outputs to each other or to the previous cycle. These are: the one-cycle valid timing, the zero upper half after a 32-bit operation, the flags holding when no flag update was requested, and the agreement of N and Z with the registered result after a flag update. The bench scenarios cover the behaviour that needs known operands. That means the carry and overflow boundaries at both widths, the subtract inversion, each shift kind and its width-specific sign fill or wrap, the zero-amount pass-through and the 32-bit amount truncation, and each extend size with and without sign.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    BSRC_RAW   = 2'd0,
    BSRC_SHIFT = 2'd1,
    BSRC_EXT   = 2'd2,
    BSRC_RAW2  = 2'd3
  } bsrc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/addsub_shift.sv
module addsub_shift #(
  parameter int XLEN = 64
) (
  input  logic                    wide,
  input  logic [1:0]              kind,
  input  logic [$clog2(XLEN)-1:0] amt_in,
  input  logic [XLEN-1:0]         val,
  output logic [XLEN-1:0]         out
);
  import addsub_pkg::*;
  localparam int HALF = XLEN / 2;
  localparam int AW   = $clog2(XLEN);

  logic [XLEN-1:0]   mask, v, sx, asr_full;
  logic [AW-1:0]     amt;
  logic [2*XLEN-1:0] dbl, rot;

  always_comb begin
    mask     = wide ? {XLEN{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
    amt      = wide ? amt_in : {1'b0, amt_in[AW-2:0]};
    v        = val & mask;
    sx       = wide ? v : {{HALF{v[HALF-1]}}, v[HALF-1:0]};
    asr_full = XLEN'($signed(sx) >>> amt);
    dbl      = wide ? {v, v} : {{XLEN{1'b0}}, v[HALF-1:0], v[HALF-1:0]};
    rot      = dbl >> amt;
    if (amt == '0) begin
      out = v;
    end else begin
      unique case (shift_kind_e'(kind))
        SH_LSL:  out = (v << amt) & mask;
        SH_LSR:  out = v >> amt;
        SH_ASR:  out = asr_full & mask;
        default: out = rot[XLEN-1:0] & mask;
      endcase
    end
  end
endmodule

// File: rtl/addsub_extend.sv
module addsub_extend #(
  parameter int XLEN   = 64,
  parameter int LSL_W  = 3
) (
  input  logic             wide,
  input  logic [2:0]       kind,
  input  logic [LSL_W-1:0] lsl,
  input  logic [XLEN-1:0]  val,
  output logic [XLEN-1:0]  out
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] mask, ext;
  logic            sgn;

  always_comb begin
    mask = wide ? {XLEN{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
    sgn  = kind[2];
    unique case (kind[1:0])
      2'd0:    ext = {{(XLEN-8){sgn & val[7]}}, val[7:0]};
      2'd1:    ext = {{(XLEN-16){sgn & val[15]}}, val[15:0]};
      2'd2:    ext = {{(XLEN-32){sgn & val[31]}}, val[31:0]};
      default: ext = val;
    endcase
    out = (ext << lsl) & mask;
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int XLEN = 64
) (
  input  logic                  wide,
  input  logic                  sub,
  input  logic                  cin,
  input  logic [XLEN-1:0]       a,
  input  logic [XLEN-1:0]       b,
  output logic [XLEN-1:0]       res,
  output addsub_pkg::flags_t    flg
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] mask, a_m, b_e;
  logic [XLEN:0]   sum;
  logic            sa, sb, sr;

  always_comb begin
    mask  = wide ? {XLEN{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
    a_m   = a & mask;
    b_e   = (sub ? ~b : b) & mask;
    sum   = {1'b0, a_m} + {1'b0, b_e} + {{XLEN{1'b0}}, cin};
    res   = sum[XLEN-1:0] & mask;
    sa    = wide ? a_m[XLEN-1] : a_m[HALF-1];
    sb    = wide ? b_e[XLEN-1] : b_e[HALF-1];
    sr    = wide ? res[XLEN-1] : res[HALF-1];
    flg.n = sr;
    flg.z = (res == '0);
    flg.c = wide ? sum[XLEN] : sum[HALF];
    flg.v = (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int XLEN  = 64,
  parameter int SAMTW = $clog2(XLEN),
  parameter int LSL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             wide,
  input  logic             sub,
  input  logic             set_flags,
  input  logic             carry_in,
  input  logic [XLEN-1:0]  op_a,
  input  logic [XLEN-1:0]  op_b,
  input  logic [1:0]       b_sel,
  input  logic [1:0]       sh_kind,
  input  logic [SAMTW-1:0] sh_amt,
  input  logic [2:0]       ext_kind,
  input  logic [LSL_W-1:0] ext_lsl,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  import addsub_pkg::*;
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] b_shift, b_ext, b_cond, sum_res;
  flags_t          sum_flg;
  logic            wide_q;

  addsub_shift #(.XLEN(XLEN)) u_shift (
    .wide(wide), .kind(sh_kind), .amt_in(sh_amt), .val(op_b), .out(b_shift)
  );

  addsub_extend #(.XLEN(XLEN), .LSL_W(LSL_W)) u_ext (
    .wide(wide), .kind(ext_kind), .lsl(ext_lsl), .val(op_b), .out(b_ext)
  );

  always_comb begin
    unique case (bsrc_e'(b_sel))
      BSRC_SHIFT: b_cond = b_shift;
      BSRC_EXT:   b_cond = b_ext;
      default:    b_cond = op_b;
    endcase
  end

  addsub_core #(.XLEN(XLEN)) u_core (
    .wide(wide), .sub(sub), .cin(carry_in), .a(op_a), .b(b_cond),
    .res(sum_res), .flg(sum_flg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      wide_q    <= 1'b1;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      flag_v    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= sum_res;
        wide_q <= wide;
        if (set_flags) begin
          flag_n <= sum_flg.n;
          flag_z <= sum_flg.z;
          flag_c <= sum_flg.c;
          flag_v <= sum_flg.v;
        end
      end
    end
  end

  AST_OUT_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    !wide_q |-> (result[XLEN-1:HALF] == '0)); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && set_flags) |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R6
  AST_Z_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && set_flags) |=> (flag_z == (result == '0))); // R5
  AST_N_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && set_flags) |=> (flag_n == (wide_q ? result[XLEN-1] : result[HALF-1]))); // R5
endmodule

// File: tb/test_addsub_flags.sv
module test_addsub_flags;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] M32 = 64'h0000_0000_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, wide = 1'b1, sub = 1'b0, set_flags = 1'b0, carry_in = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  b_sel = '0, sh_kind = '0;
  logic [5:0]  sh_amt = '0;
  logic [2:0]  ext_kind = '0, ext_lsl = '0;
  logic        out_valid, flag_n, flag_z, flag_c, flag_v;
  logic [63:0] result;

  int checks = 0, errors = 0;
  logic [3:0] held_flags = 4'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_flags i_addsub_flags (
    .clk(clk), .rst(rst), .in_valid(in_valid), .wide(wide), .sub(sub),
    .set_flags(set_flags), .carry_in(carry_in), .op_a(op_a), .op_b(op_b),
    .b_sel(b_sel), .sh_kind(sh_kind), .sh_amt(sh_amt), .ext_kind(ext_kind),
    .ext_lsl(ext_lsl), .out_valid(out_valid), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic check(input string req, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference for operand B' built from the requirement text.
  function automatic logic [63:0] ref_b(input logic w, input logic [63:0] b,
      input logic [1:0] sel, input logic [1:0] k, input logic [5:0] amt_raw,
      input logic [2:0] ek, input logic [2:0] el);
    logic [63:0] msk = w ? '1 : M32;
    int width = w ? 64 : 32;
    int amt = w ? int'(amt_raw) : int'(amt_raw[4:0]);
    logic [63:0] x = b & msk;
    logic [63:0] e;
    if (sel == 2'd1) begin
      for (int i = 0; i < amt; i++) begin
        case (k)
          2'd0: x = (x << 1) & msk;
          2'd1: x = x >> 1;
          2'd2: x = (x >> 1) | (x & (64'd1 << (width-1)));
          default: x = (x >> 1) | ({63'd0, x[0]} << (width-1));
        endcase
      end
      return x;
    end else if (sel == 2'd2) begin
      case (ek[1:0])
        2'd0: e = ek[2] ? 64'($signed(b[7:0]))  : {56'd0, b[7:0]};
        2'd1: e = ek[2] ? 64'($signed(b[15:0])) : {48'd0, b[15:0]};
        2'd2: e = ek[2] ? 64'($signed(b[31:0])) : {32'd0, b[31:0]};
        default: e = b;
      endcase
      return (e << el) & msk;
    end
    return b;
  endfunction

  function automatic logic [67:0] ref_op(input logic w, input logic s,
      input logic ci, input logic [63:0] a, input logic [63:0] bp);
    logic [63:0]  msk = w ? '1 : M32;
    int           top = w ? 63 : 31;
    logic [63:0]  am = a & msk;
    logic [63:0]  bt = (s ? ~bp : bp) & msk;
    logic [127:0] wsum = 128'(am) + 128'(bt) + 128'(ci);
    logic [63:0]  r = wsum[63:0] & msk;
    logic c = (wsum > 128'(msk));
    logic v = (am[top] == bt[top]) && (r[top] != am[top]);
    return {r[top], (r == 0), c, v, r};
  endfunction

  task automatic run(input string req, input logic w, input logic s, input logic sf,
      input logic ci, input logic [63:0] a, input logic [63:0] b, input logic [1:0] sel,
      input logic [1:0] k, input logic [5:0] amt, input logic [2:0] ek, input logic [2:0] el);
    logic [67:0] exp;
    @(negedge clk);
    in_valid = 1; wide = w; sub = s; set_flags = sf; carry_in = ci;
    op_a = a; op_b = b; b_sel = sel; sh_kind = k; sh_amt = amt; ext_kind = ek; ext_lsl = el;
    exp = ref_op(w, s, ci, a, ref_b(w, b, sel, k, amt, ek, el));
    if (sf) held_flags = exp[67:64];
    @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, {67'd0, out_valid}, 68'd1);
    check(req, {flag_n, flag_z, flag_c, flag_v, result}, {held_flags, exp[63:0]});
  endtask

  task automatic t_reset();
    check("R1 reset", {out_valid, flag_n, flag_z, flag_c, flag_v, result[62:0]}, 68'd0);
  endtask

  task automatic t_add_basic();
    run("R3 add64", 1, 0, 1, 0, 64'd5, 64'd7, 0, 0, 0, 0, 0);
    check("R3 add64 value", {4'd0, result}, 68'd12);
    run("R3 add carry-in", 1, 0, 1, 1, 64'd100, 64'd23, 0, 0, 0, 0, 0);
  endtask

  task automatic t_width32();
    run("R2 trunc32", 0, 0, 1, 0, 64'hFFFF_FFFF_0000_0001, 64'h1234_0000_0000_0002, 3, 0, 0, 0, 0);
    check("R2 upper zero", {4'd0, result}, 68'd3);
  endtask

  task automatic t_carry();
    run("R4 carry32", 0, 0, 1, 1, 64'hFFFF_FFFF, 64'd0, 0, 0, 0, 0, 0);
    check("R4 carry32 flags", {64'd0, flag_n, flag_z, flag_c, flag_v}, 68'b0110);
    run("R4 carry64", 1, 0, 1, 0, '1, 64'd2, 0, 0, 0, 0, 0);
  endtask

  task automatic t_overflow();
    run("R5 ovf64", 1, 0, 1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 0);
    check("R5 ovf64 flags", {64'd0, flag_n, flag_z, flag_c, flag_v}, 68'b1001);
    run("R5 ovf32", 0, 0, 1, 0, 64'h7FFF_FFFF, 64'd1, 0, 0, 0, 0, 0);
    run("R5 neg ovf32", 0, 0, 1, 0, 64'h8000_0000, 64'h8000_0000, 0, 0, 0, 0, 0);
  endtask

  task automatic t_subtract();
    run("R3 sub borrow", 1, 1, 1, 1, 64'd3, 64'd5, 0, 0, 0, 0, 0);
    check("R3 sub value", {4'd0, result}, {4'd0, 64'hFFFF_FFFF_FFFF_FFFE});
    run("R3 sub no borrow", 0, 1, 1, 1, 64'd5, 64'd3, 0, 0, 0, 0, 0);
    run("R5 sub equal", 0, 1, 1, 1, 64'hABCD, 64'hABCD, 0, 0, 0, 0, 0);
  endtask

  task automatic t_shifts();
    for (int k = 0; k < 4; k++) begin
      run("R8 shift64", 1, 0, 1, 0, 64'd1, 64'h8000_0000_0000_00F1, 1, 2'(k), 6'd4, 0, 0);
      run("R8 shift32", 0, 0, 1, 0, 64'd0, 64'hFFFF_FFFF_8000_00F1, 1, 2'(k), 6'd4, 0, 0);
    end
    run("R8 asr32 fill", 0, 0, 0, 0, 64'd0, 64'h0000_0000_8000_0000, 1, 2, 6'd31, 0, 0);
    check("R8 asr32 value", {4'd0, result}, {4'd0, M32});
    run("R8 ror32 wrap", 0, 0, 0, 0, 64'd0, 64'd1, 1, 3, 6'd1, 0, 0);
    check("R8 ror32 value", {4'd0, result}, 68'h0_0000_0000_8000_0000);
  endtask

  task automatic t_shift_amount();
    for (int k = 0; k < 4; k++)
      run("R9 zero amount", 1, 0, 0, 0, 64'd0, 64'hDEAD_BEEF_0123_4567, 1, 2'(k), 6'd0, 0, 0);
    run("R9 amt32 low bits", 0, 0, 0, 0, 64'd0, 64'd3, 1, 0, 6'd33, 0, 0);
    check("R9 amt32 value", {4'd0, result}, 68'd6);
  endtask

  task automatic t_extend();
    for (int ek = 0; ek < 8; ek++)
      run("R10 extend64", 1, 0, 1, 0, 64'd0, 64'h8888_8888_8888_8888, 2, 2'd0, 0, 3'(ek), 3'(ek % 5));
    run("R10 sxtb lsl2", 1, 0, 0, 0, 64'd0, 64'h80, 2, 0, 0, 3'd4, 3'd2);
    check("R10 sxtb value", {4'd0, result}, {4'd0, 64'hFFFF_FFFF_FFFF_FE00});
    run("R10 sxth 32", 0, 0, 1, 0, 64'd1, 64'h8001, 2, 0, 0, 3'd5, 3'd4);
  endtask

  task automatic t_select_raw();
    run("R7 raw sel3", 1, 0, 1, 0, 64'd10, 64'h8000_0000_0000_0000, 3, 1, 6'd5, 0, 0);
    check("R7 raw ignores shift", {4'd0, result}, {4'd0, 64'h8000_0000_0000_000A});
  endtask

  task automatic t_flag_hold();
    run("R6 set", 1, 0, 1, 0, 64'd0, 64'd0, 0, 0, 0, 0, 0);
    run("R6 hold", 1, 0, 0, 1, '1, 64'd5, 0, 0, 0, 0, 0);
    check("R6 held flags", {64'd0, flag_n, flag_z, flag_c, flag_v}, 68'b0100);
    @(negedge clk);
    check("R1 valid drops", {67'd0, out_valid}, 68'd0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_add_basic();
        t_width32();
        t_carry();
        t_overflow();
        t_subtract();
        t_shifts();
        t_shift_amount();
        t_extend();
        t_select_raw();
        t_flag_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule